// File: doc/BRIEF.md
# Warp Issue Scheduler

This block picks which resident warp sends its next instruction into a lane array of a streaming multiprocessor model. A warp is a group of threads (32 by default) that shares one instruction unit. The lane array has fewer scalar lanes than a warp has threads (8 by default), so one warp instruction runs as a sequence of lane groups, one group per cycle: four cycles with the defaults. Any eligible warp may follow any other with no switch penalty. A warp that is stalled, or that waits at a barrier, is skipped and does not hold up the others. Eligible warps are taken in round-robin order, starting from the warp after the one issued last.

The block also contains a block-wide barrier. A mask chooses the warps that take part. Each arriving warp sends a single-cycle strobe and is then held out of issue. When the last member arrives, all members are released together and the barrier is ready for its next use.

The issue side is a valid/ready stream. `issue_valid` and `issue_warp` show the current offer. An issue happens only in a cycle where `issue_valid` and `issue_ready` are both high. The offer is recomputed every cycle from the stall, ready and barrier state, so it is not held while `issue_ready` is low. A consumer that holds `issue_ready` low starts nothing, and no scheduler state moves.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, `issue_valid` and `lane_active` are low and no warp is held at the barrier. The first warp offered is the lowest-numbered eligible warp.
- R2: An issue in cycle t drives `lane_active` high for exactly WARP_THREADS/NUM_LANES cycles, starting at t+1. During those cycles `lane_grp` counts 0,1,2,3 and `lane_warp` equals the accepted warp. `lane_grp` reads 0 when the lanes are idle.
- R3: The offered warp is the first eligible warp after the last accepted warp, in increasing index order with wrap-around.
- R4: A warp is eligible when its `warp_ready` bit is high, its `warp_stall` bit is low and it is not held at the barrier. A stalled warp is never offered, and the other eligible warps are still offered.
- R5: An offer is made only while the lanes are idle or in their last lane group. Back-to-back issues therefore keep the lanes busy with no idle cycle between them.
- R6: When no warp is eligible, `issue_valid` is low.
- R7: Without `issue_ready` nothing is issued. The lanes stay idle and the round-robin position does not move.
- R8: A `bar_arrive` strobe from a warp whose `bar_member` bit is high holds that warp out of issue from the next cycle until the barrier releases.
- R9: `bar_release` is high in the cycle in which every member has arrived, counting strobes in that same cycle. From the next cycle no member is held.
- R10: After a release the barrier starts over. A later group of arrivals forms a new episode and releases only when all members have arrived again.
- R11: Arrival strobes from non-member warps are ignored, and an empty member mask never releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NUM_WARPS | Warp has an instruction waiting |
| warp_stall | input | NUM_WARPS | Warp waits on memory or another event |
| bar_arrive | input | NUM_WARPS | Single-cycle barrier arrival strobe per warp |
| bar_member | input | NUM_WARPS | Warps taking part in the barrier |
| issue_ready | input | 1 | Consumer accepts the offered warp |
| issue_valid | output | 1 | An eligible warp is offered |
| issue_warp | output | WID_W | Index of the offered warp |
| lane_active | output | 1 | Lanes are executing a warp instruction |
| lane_grp | output | GRP_W | Current lane group of that instruction |
| lane_warp | output | WID_W | Warp whose instruction occupies the lanes |
| bar_release | output | 1 | Barrier releases its members this cycle |

## Verification
Barrier release and issue selection can fall in the same cycle. The stimulus sends the last member's arrival strobe while the lanes are in their final group and other warps are offered. The bench then judges two things: the offer in the release cycle still excludes the held members, and the released warps become eligible in round-robin order from the next cycle. Stall changes that coincide with a release are also applied, so that eligibility built from both sources is compared every clock against the behavioural model.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  typedef enum logic {
    LANE_IDLE = 1'b0,
    LANE_RUN  = 1'b1
  } lane_state_e;

  // width of an index that counts n items, never below one bit
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] pick
);

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!any && req[idx]) begin
        any  = 1'b1;
        pick = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/warp_barrier.sv
module warp_barrier #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arrive,
  input  logic [N-1:0] member,
  output logic [N-1:0] held,
  output logic         release_now
);

  logic [N-1:0] arrived;

  always_comb begin
    arrived     = held | (arrive & member);
    release_now = (|member) && ((arrived & member) == member);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           held <= '0;
    else if (release_now) held <= '0;
    else                  held <= arrived;
  end

endmodule

// File: rtl/warp_lane_seq.sv
module warp_lane_seq
  import warp_sched_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int GW     = 2,
  parameter int IW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] start_warp,
  output logic          active,
  output logic [GW-1:0] grp,
  output logic [IW-1:0] warp,
  output logic          slot_open
);

  localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

  lane_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= LANE_IDLE;
      grp  <= '0;
      warp <= '0;
    end else if (start) begin
      st   <= LANE_RUN;
      grp  <= '0;
      warp <= start_warp;
    end else if (st == LANE_RUN) begin
      if (grp == LAST_GRP) begin
        st  <= LANE_IDLE;
        grp <= '0;
      end else begin
        grp <= grp + 1'b1;
      end
    end
  end

  assign active    = (st == LANE_RUN);
  assign slot_open = (st == LANE_IDLE) || (grp == LAST_GRP);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS    = 8,
  parameter int WARP_THREADS = 32,
  parameter int NUM_LANES    = 8,
  localparam int GROUPS = WARP_THREADS / NUM_LANES,
  localparam int WID_W  = idx_width(NUM_WARPS),
  localparam int GRP_W  = idx_width(GROUPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_ready,
  input  logic [NUM_WARPS-1:0] warp_stall,
  input  logic [NUM_WARPS-1:0] bar_arrive,
  input  logic [NUM_WARPS-1:0] bar_member,
  input  logic                 issue_ready,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic                 lane_active,
  output logic [GRP_W-1:0]     lane_grp,
  output logic [WID_W-1:0]     lane_warp,
  output logic                 bar_release
);

  logic [NUM_WARPS-1:0] bar_wait_q;
  logic [NUM_WARPS-1:0] eligible;
  logic [WID_W-1:0]     last_q;
  logic                 any_elig;
  logic [WID_W-1:0]     pick;
  logic                 slot_open;
  logic                 fire;

  warp_barrier #(.N(NUM_WARPS)) u_bar (
    .clk         (clk),
    .rst_n       (rst_n),
    .arrive      (bar_arrive),
    .member      (bar_member),
    .held        (bar_wait_q),
    .release_now (bar_release)
  );

  assign eligible = warp_ready & ~warp_stall & ~bar_wait_q;

  warp_rr_pick #(.N(NUM_WARPS), .IW(WID_W)) u_pick (
    .req  (eligible),
    .last (last_q),
    .any  (any_elig),
    .pick (pick)
  );

  warp_lane_seq #(.GROUPS(GROUPS), .GW(GRP_W), .IW(WID_W)) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fire),
    .start_warp (pick),
    .active     (lane_active),
    .grp        (lane_grp),
    .warp       (lane_warp),
    .slot_open  (slot_open)
  );

  assign issue_valid = slot_open && any_elig;
  assign issue_warp  = pick;
  assign fire        = issue_valid && issue_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= WID_W'(NUM_WARPS - 1);
    else if (fire) last_q <= pick;
  end

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 8,
  parameter int WID_W     = 3,
  parameter int GRP_W     = 2,
  parameter int GROUPS    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] warp_ready,
  input logic [NUM_WARPS-1:0] warp_stall,
  input logic [NUM_WARPS-1:0] bar_member,
  input logic [NUM_WARPS-1:0] bar_wait_q,
  input logic                 issue_ready,
  input logic                 issue_valid,
  input logic [WID_W-1:0]     issue_warp,
  input logic                 lane_active,
  input logic [GRP_W-1:0]     lane_grp,
  input logic [WID_W-1:0]     lane_warp,
  input logic                 bar_release
);

  localparam logic [GRP_W-1:0] LASTG = GRP_W'(GROUPS - 1);

  assert_issue_starts_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_ready |=> lane_active && lane_grp == '0 && lane_warp == $past(issue_warp));

  assert_group_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_active && lane_grp != LASTG && !(issue_valid && issue_ready)
      |=> lane_active && lane_grp == $past(lane_grp) + 1'b1 && $stable(lane_warp));

  assert_offer_only_at_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !lane_active || lane_grp == LASTG);

  assert_offer_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> warp_ready[issue_warp] && !warp_stall[issue_warp]);

  assert_held_not_offered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !bar_wait_q[issue_warp]);

  assert_release_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bar_release |=> bar_wait_q == '0);

  assert_empty_mask_no_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bar_release |-> bar_member != '0);

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .WID_W(WID_W), .GRP_W(GRP_W), .GROUPS(GROUPS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .warp_ready  (warp_ready),
  .warp_stall  (warp_stall),
  .bar_member  (bar_member),
  .bar_wait_q  (bar_wait_q),
  .issue_ready (issue_ready),
  .issue_valid (issue_valid),
  .issue_warp  (issue_warp),
  .lane_active (lane_active),
  .lane_grp    (lane_grp),
  .lane_warp   (lane_warp),
  .bar_release (bar_release)
);

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] warp_ready = '0;
  logic [NW-1:0] warp_stall = '0;
  logic [NW-1:0] bar_arrive = '0;
  logic [NW-1:0] bar_member = '0;
  logic          issue_ready = 1'b0;
  logic          issue_valid;
  logic [2:0]    issue_warp;
  logic          lane_active;
  logic [1:0]    lane_grp;
  logic [2:0]    lane_warp;
  logic          bar_release;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_busy;
  int          m_grp;
  int          m_warp;
  int          m_last;
  bit [NW-1:0] m_wait;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_stall(warp_stall),
    .bar_arrive(bar_arrive), .bar_member(bar_member), .issue_ready(issue_ready),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .lane_active(lane_active),
    .lane_grp(lane_grp), .lane_warp(lane_warp), .bar_release(bar_release)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input logic [NW-1:0] rdy, input logic [NW-1:0] stl,
                      input logic [NW-1:0] arr, input logic [NW-1:0] mem,
                      input bit ir, input string tag);
    bit [NW-1:0] elig;
    bit [NW-1:0] arrived;
    bit exp_valid, rel, fire;
    int exp_warp;
    @(negedge clk);
    warp_ready = rdy; warp_stall = stl; bar_arrive = arr;
    bar_member = mem; issue_ready = ir;
    #1;
    elig = rdy & ~stl & ~m_wait;
    exp_warp = 0;
    exp_valid = 0;
    if (!m_busy || m_grp == NG - 1) begin
      for (int k = 1; k <= NW; k++) begin
        int w;
        w = (m_last + k) % NW;
        if (!exp_valid && elig[w]) begin exp_valid = 1; exp_warp = w; end
      end
    end
    arrived = m_wait | (arr & mem);
    rel = (mem != 0) && ((arrived & mem) == mem);
    check({tag, " valid"}, int'(issue_valid), int'(exp_valid));
    if (exp_valid) check("R3 offered warp", int'(issue_warp), exp_warp);
    check("R2 lane_active", int'(lane_active), int'(m_busy));
    check("R2 lane_grp", int'(lane_grp), m_grp);
    if (m_busy) check("R2 lane_warp", int'(lane_warp), m_warp);
    check("R9 bar_release", int'(bar_release), int'(rel));
    // advance the reference to the state after the next edge
    fire = exp_valid && ir;
    if (fire) begin
      m_busy = 1; m_grp = 0; m_warp = exp_warp; m_last = exp_warp;
    end else if (m_busy) begin
      if (m_grp == NG - 1) begin m_busy = 0; m_grp = 0; end
      else m_grp++;
    end
    m_wait = rel ? '0 : arrived;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_busy = 0; m_grp = 0; m_warp = 0; m_last = NW - 1; m_wait = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 valid in reset", int'(issue_valid), 0);
    check("R1 lanes in reset", int'(lane_active), 0);
    @(negedge clk); rst_n = 1'b1;
    step('0, '0, '0, '0, 1, "R1");
    step('0, '0, '0, '0, 1, "R6");
    // first offer must be warp 0 after reset
    step(8'hFF, '0, '0, '0, 1, "R1");
    for (int i = 0; i < 24; i++) step(8'hFF, '0, '0, '0, 1, "R3");
    for (int i = 0; i < 12; i++) step(8'hFF, 8'b0101_0010, '0, '0, 1, "R4");
    for (int i = 0; i < 12; i++) step(8'b1011_1111, 8'b1110_0000, '0, '0, 1, "R4");
    for (int i = 0; i < 6; i++)  step('0, '0, '0, '0, 1, "R6");
    for (int i = 0; i < 6; i++)  step(8'b0010_0000, 8'b0010_0000, '0, '0, 1, "R6");
    for (int i = 0; i < 8; i++)  step(8'hFF, '0, '0, '0, 0, "R7");
    for (int i = 0; i < 12; i++) step(8'hFF, '0, '0, '0, 1, "R5");
    // barrier episode one, members 0..3
    step(8'hFF, '0, 8'h01, 8'h0F, 1, "R8");
    for (int i = 0; i < 4; i++) step(8'hFF, '0, '0, 8'h0F, 1, "R8");
    step(8'hFF, '0, 8'h02, 8'h0F, 1, "R8");
    for (int i = 0; i < 3; i++) step(8'hFF, '0, '0, 8'h0F, 1, "R8");
    step(8'hFF, '0, 8'h44, 8'h0F, 1, "R11");
    for (int i = 0; i < 6; i++) step(8'hFF, '0, '0, 8'h0F, 1, "R8");
    step(8'hFF, '0, 8'h08, 8'h0F, 1, "R9");
    for (int i = 0; i < 6; i++) step(8'hFF, '0, '0, 8'h0F, 1, "R9");
    // episode two
    step(8'hFF, '0, 8'h0C, 8'h0F, 1, "R10");
    for (int i = 0; i < 5; i++) step(8'hFF, '0, '0, 8'h0F, 1, "R10");
    step(8'hFF, 8'h30, 8'h03, 8'h0F, 1, "R10");
    for (int i = 0; i < 6; i++) step(8'hFF, '0, '0, 8'h0F, 1, "R10");
    // empty mask: strobes ignored
    for (int i = 0; i < 3; i++) step(8'hFF, '0, 8'hFF, '0, 1, "R11");
    for (int i = 0; i < 5; i++) step(8'hFF, '0, '0, '0, 1, "R11");
    // release coinciding with issue slots, stalls changing at the same time
    for (int j = 0; j < 4; j++) begin
      step(8'hFF, '0, 8'h01, 8'h03, 1, "R8");
      for (int i = 0; i < j + 1; i++) step(8'hFF, 8'h04, '0, 8'h03, 1, "R4");
      step(8'hFF, 8'hF0, 8'h02, 8'h03, 1, "R9");
      for (int i = 0; i < 6; i++) step(8'hFF, 8'h0C, '0, 8'h03, 1, "R3");
    end
    finish_run();
  end

endmodule